// File: doc/BRIEF.md
# Audio Frame-Rate Clock Enable Generator

This block sits in the digital core of an audio codec. It derives every frame timing signal from one fast core clock and never creates a new clock net. Two tick inputs mark the edges of the master clock and of an external PLL clock. A select input chooses which tick stream to use. A pre-divider then either passes that stream unchanged or halves it, and the result is the system tick.

Two frame dividers count system ticks: one for the converter input path (ADC) and one for the output path (DAC). Each divider has its own 3-bit rate code, and together the codes cover frame lengths of 256, 384, 512, 768, 1024, 1408 and 1536 system ticks. Each divider drives a square-wave left/right frame clock for master mode, a one-cycle frame-start strobe and an error flag for the reserved code. A code written in the middle of a frame is held until that frame ends, so reprogramming never produces a short or stretched frame.

Top module: `audio_rate_clkgen`

## Requirements
- R1: With `srcSel` at 0 the system tick follows `mclkTick`, and with `srcSel` at 1 it follows `pllTick`. The tick input that is not selected has no effect on any output.
- R2: A pre-divider code of 2'b10 passes only every second selected source tick, so two system ticks never occur in consecutive cycles.
- R3: The pre-divider codes 2'b00, 2'b01 and 2'b11 all pass every selected source tick. This means the two reserved codes act as divide by 1.
- R4: A frame lasts a number of system ticks set by the rate code: 3'b000 gives 256, 3'b001 gives 384, 3'b010 gives 512, 3'b011 gives 768, 3'b100 gives 1024, 3'b101 gives 1408 and 3'b110 gives 1536.
- R5: The ADC and DAC dividers run independently. Each follows only its own rate code, so the two can hold different frame lengths at the same time.
- R6: Each frame clock is high for exactly the first half of the system ticks of a frame (the left channel) and low for the second half.
- R7: A frame-start strobe is high for one cycle at the start of each frame, in the same cycle in which the frame clock rises.
- R8: Rate code 3'b111 is reserved. When a divider reaches a frame boundary with this code applied, its frame clock stays low, it gives no start strobes and its error flag is high. On the next system tick after a valid code is applied, the divider starts a frame and clears the flag.
- R9: A rate code that changes in the middle of a frame takes effect only at the next frame boundary. The frame already in progress keeps its full length.
- R10: A synchronous active-high reset clears the counters and drives the system tick, both frame clocks, both start strobes and both error flags low in the cycle that follows.
- R11: Frame clocks, strobes and error flags change only in the cycle after a system tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| srcSel | input | 1 | Source select: 0 = master clock ticks, 1 = PLL ticks |
| mclkTick | input | 1 | One-cycle pulse per master clock edge |
| pllTick | input | 1 | One-cycle pulse per PLL clock edge |
| preDivCode | input | 2 | Pre-divider code (2'b10 halves the rate, all other codes divide by 1) |
| adcRateCode | input | 3 | ADC frame rate code |
| dacRateCode | input | 3 | DAC frame rate code |
| sysTick | output | 1 | System clock enable |
| adcFrameClk | output | 1 | ADC left/right frame clock |
| adcFrameStart | output | 1 | ADC frame-start strobe |
| adcRateErr | output | 1 | ADC reserved-code flag |
| dacFrameClk | output | 1 | DAC left/right frame clock |
| dacFrameStart | output | 1 | DAC frame-start strobe |
| dacRateErr | output | 1 | DAC reserved-code flag |

## Verification
The assertions check several rules on every cycle. A system tick must trace back to a pulse on the selected source, and the halved rate must never give back-to-back ticks. Each start strobe must coincide with a high frame clock and must last a single cycle. A stopped divider must stay quiet, and frame outputs must hold still between ticks.

Other behaviour can only be shown by the bench's scenarios. These are the actual frame length and high time for every rate code, the independence of the two dividers and the full-length completion of a frame interrupted by a code change. The restart after a reserved code is also covered there, as are the divide-by-1 treatment of reserved pre-divider codes and the rejection of the unselected source.

// File: rtl/arc_pkg.sv
package arc_pkg;

  // Number of frame dividers: index 0 is the ADC path, index 1 is the DAC path
  localparam int ARC_CH = 2;

  // Per-channel strobes from the control logic to the datapath
  typedef struct packed {
    logic [ARC_CH-1:0] load;  // start a new frame with the code now applied
    logic [ARC_CH-1:0] stop;  // boundary reached with the reserved code
    logic [ARC_CH-1:0] step;  // advance inside the current frame
  } arcStrobe_t;

  // Frame length in units of half the base divide; 0 means the code is reserved
  function automatic int unsigned halfUnits(input logic [2:0] code);
    case (code)
      3'd0:    return 2;
      3'd1:    return 3;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 11;
      3'd6:    return 12;
      default: return 0;
    endcase
  endfunction

  function automatic logic codeValid(input logic [2:0] code);
    return code != 3'b111;
  endfunction

endpackage

// File: rtl/arc_clk_ctrl.sv
module arc_clk_ctrl
  import arc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    srcSel,
  input  logic                    mclkTick,
  input  logic                    pllTick,
  input  logic [1:0]              preDivCode,
  input  logic [ARC_CH-1:0][2:0]  rateCode,
  input  logic [ARC_CH-1:0]       boundary,
  output logic                    sysTick,
  output arcStrobe_t              strobe
);

  logic srcTick;
  logic halveRate;
  logic phase;
  logic sysTickQ;

  assign srcTick   = srcSel ? pllTick : mclkTick;
  // Only 2'b10 halves the rate; the reserved codes fall back to divide by 1
  assign halveRate = (preDivCode == 2'b10);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      sysTickQ <= 1'b0;
    end else begin
      if (srcTick) phase <= ~phase;
      sysTickQ <= srcTick && (!halveRate || phase);
    end
  end

  assign sysTick = sysTickQ;

  for (genvar ch = 0; ch < ARC_CH; ch++) begin : g_strobe
    logic okCode;
    assign okCode = codeValid(rateCode[ch]);
    always_comb begin
      strobe.load[ch] = sysTickQ &&  boundary[ch] &&  okCode;
      strobe.stop[ch] = sysTickQ &&  boundary[ch] && !okCode;
      strobe.step[ch] = sysTickQ && !boundary[ch];
    end
  end

endmodule

// File: rtl/arc_frame_dp.sv
module arc_frame_dp
  import arc_pkg::*;
#(
  parameter int BASE_DIV = 256   // base frame length; must be a multiple of 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  arcStrobe_t              strobe,
  input  logic [ARC_CH-1:0][2:0]  rateCode,
  output logic [ARC_CH-1:0]       boundary,
  output logic [ARC_CH-1:0]       frameClk,
  output logic [ARC_CH-1:0]       frameStart,
  output logic [ARC_CH-1:0]       rateErr
);

  localparam int HALF_BASE    = BASE_DIV / 2;
  localparam int QUARTER_BASE = BASE_DIV / 4;
  localparam int CNT_W        = $clog2(6 * BASE_DIV);

  for (genvar ch = 0; ch < ARC_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cntInc;
    logic [CNT_W-1:0] lastCnt;
    logic [CNT_W-1:0] halfCnt;
    logic [2:0]       activeCode;
    logic             running;
    logic             fclkQ;
    logic             startQ;
    logic             errQ;

    always_comb begin
      lastCnt = CNT_W'(halfUnits(activeCode) * HALF_BASE - 1);
      halfCnt = CNT_W'(halfUnits(activeCode) * QUARTER_BASE);
      cntInc  = cnt + CNT_W'(1);
    end

    assign boundary[ch] = !running || (cnt == lastCnt);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt        <= '0;
        activeCode <= 3'd0;
        running    <= 1'b0;
        fclkQ      <= 1'b0;
        startQ     <= 1'b0;
        errQ       <= 1'b0;
      end else if (strobe.load[ch]) begin
        cnt        <= '0;
        activeCode <= rateCode[ch];
        running    <= 1'b1;
        fclkQ      <= 1'b1;
        startQ     <= 1'b1;
        errQ       <= 1'b0;
      end else if (strobe.stop[ch]) begin
        cnt     <= '0;
        running <= 1'b0;
        fclkQ   <= 1'b0;
        startQ  <= 1'b0;
        errQ    <= 1'b1;
      end else if (strobe.step[ch]) begin
        cnt    <= cntInc;
        fclkQ  <= (cntInc < halfCnt);
        startQ <= 1'b0;
      end else begin
        startQ <= 1'b0;
      end
    end

    assign frameClk[ch]   = fclkQ;
    assign frameStart[ch] = startQ;
    assign rateErr[ch]    = errQ;
  end

endmodule

// File: rtl/audio_rate_clkgen.sv
module audio_rate_clkgen
  import arc_pkg::*;
#(
  parameter int BASE_DIV = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       srcSel,
  input  logic       mclkTick,
  input  logic       pllTick,
  input  logic [1:0] preDivCode,
  input  logic [2:0] adcRateCode,
  input  logic [2:0] dacRateCode,
  output logic       sysTick,
  output logic       adcFrameClk,
  output logic       adcFrameStart,
  output logic       adcRateErr,
  output logic       dacFrameClk,
  output logic       dacFrameStart,
  output logic       dacRateErr
);

  logic [ARC_CH-1:0][2:0] rateCode;
  logic [ARC_CH-1:0]      boundary;
  logic [ARC_CH-1:0]      frameClk;
  logic [ARC_CH-1:0]      frameStart;
  logic [ARC_CH-1:0]      rateErr;
  arcStrobe_t             strobe;

  assign rateCode = {dacRateCode, adcRateCode};

  arc_clk_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .srcSel     (srcSel),
    .mclkTick   (mclkTick),
    .pllTick    (pllTick),
    .preDivCode (preDivCode),
    .rateCode   (rateCode),
    .boundary   (boundary),
    .sysTick    (sysTick),
    .strobe     (strobe)
  );

  arc_frame_dp #(.BASE_DIV(BASE_DIV)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .rateCode   (rateCode),
    .boundary   (boundary),
    .frameClk   (frameClk),
    .frameStart (frameStart),
    .rateErr    (rateErr)
  );

  assign adcFrameClk   = frameClk[0];
  assign adcFrameStart = frameStart[0];
  assign adcRateErr    = rateErr[0];
  assign dacFrameClk   = frameClk[1];
  assign dacFrameStart = frameStart[1];
  assign dacRateErr    = rateErr[1];

endmodule

// File: rtl/arc_checker.sv
module arc_checker (
  input logic       clk,
  input logic       rst,
  input logic       srcSel,
  input logic       mclkTick,
  input logic       pllTick,
  input logic [1:0] preDivCode,
  input logic [2:0] adcRateCode,
  input logic [2:0] dacRateCode,
  input logic       sysTick,
  input logic       adcFrameClk,
  input logic       adcFrameStart,
  input logic       adcRateErr,
  input logic       dacFrameClk,
  input logic       dacFrameStart,
  input logic       dacRateErr
);

  p_src_select_r1: assert property (@(posedge clk) disable iff (rst)
    sysTick |-> $past(srcSel ? pllTick : mclkTick));

  p_halve_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (preDivCode == 2'b10 && $past(preDivCode) == 2'b10 && sysTick) |=> !sysTick);

  p_start_high_r7: assert property (@(posedge clk) disable iff (rst)
    (adcFrameStart |-> adcFrameClk) and (dacFrameStart |-> dacFrameClk));

  p_start_single_r7: assert property (@(posedge clk) disable iff (rst)
    (adcFrameStart |=> !adcFrameStart) and (dacFrameStart |=> !dacFrameStart));

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (adcRateErr |-> (!adcFrameClk && !adcFrameStart)) and
    (dacRateErr |-> (!dacFrameClk && !dacFrameStart)));

  p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (rst)
    !sysTick |=> ($stable(adcFrameClk) && $stable(adcRateErr) && !adcFrameStart &&
                  $stable(dacFrameClk) && $stable(dacRateErr) && !dacFrameStart));

  p_reset_clear_r10: assert property (@(posedge clk)
    $past(rst) |-> (!sysTick && !adcFrameClk && !adcFrameStart && !adcRateErr &&
                    !dacFrameClk && !dacFrameStart && !dacRateErr));

endmodule

bind audio_rate_clkgen arc_checker u_chk (.*);

// File: tb/test_audio_rate_clkgen.sv
module test_audio_rate_clkgen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       srcSel = 1'b0;
  logic       mclkTick = 1'b0;
  logic       pllTick = 1'b0;
  logic [1:0] preDivCode = 2'b00;
  logic [2:0] adcRateCode = 3'd0;
  logic [2:0] dacRateCode = 3'd0;
  logic       sysTick;
  logic       adcFrameClk, adcFrameStart, adcRateErr;
  logic       dacFrameClk, dacFrameStart, dacRateErr;

  int checks = 0;
  int fails = 0;
  int mclkGap = 1;
  int pllGap = 3;
  int phaseCnt = 0;

  always #2 clk = ~clk;

  audio_rate_clkgen i_audio_rate_clkgen (.*);

  initial begin
    forever begin
      @(negedge clk);
      phaseCnt++;
      mclkTick = (phaseCnt % mclkGap) == 0;
      pllTick  = (phaseCnt % pllGap) == 0;
    end
  end

  function automatic int framelen(input int code);
    int hu[7] = '{2, 3, 4, 6, 8, 11, 12};
    return hu[code] * 128;
  endfunction

  function automatic logic startOf(input bit dac);
    return dac ? dacFrameStart : adcFrameStart;
  endfunction

  function automatic logic fclkOf(input bit dac);
    return dac ? dacFrameClk : adcFrameClk;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure(input bit dac, output int per, output int hi);
    int n = 0;
    do begin @(negedge clk); n++; end while (!startOf(dac) && n < 5000);
    per = 0;
    hi = 0;
    do begin
      @(negedge clk);
      per++;
      if (fclkOf(dac)) hi++;
    end while (!startOf(dac) && per < 20000);
  endtask

  task automatic checkFrame(input bit dac, input int code, input int spacing, input string tag);
    int per, hi;
    measure(dac, per, hi);
    check(per == framelen(code) * spacing, tag, per, framelen(code) * spacing);
    check(hi == framelen(code) * spacing / 2, "R6 duty", hi, framelen(code) * spacing / 2);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, per, hi, seen;
    repeat (3) @(negedge clk);
    // R10: outputs after reset
    check(!sysTick, "R10 sysTick", sysTick, 0);
    check(!adcFrameClk && !dacFrameClk, "R10 frame clocks", adcFrameClk | dacFrameClk, 0);
    check(!adcFrameStart && !dacFrameStart, "R10 strobes", adcFrameStart | dacFrameStart, 0);
    check(!adcRateErr && !dacRateErr, "R10 error flags", adcRateErr | dacRateErr, 0);
    rst = 1'b0;

    // R4 and R5: every code, the two dividers on different codes
    for (int i = 0; i < 7; i++) begin
      adcRateCode = 3'(i);
      dacRateCode = 3'(6 - i);
      checkFrame(1'b0, i, 1, "R4 adc period");
      checkFrame(1'b1, 6 - i, 1, "R5 dac period");
    end

    adcRateCode = 3'd0;
    dacRateCode = 3'd0;
    // R2: halved rate
    preDivCode = 2'b10;
    checkFrame(1'b0, 0, 2, "R2 halved period");
    // R3: reserved pre-divider codes act as divide by 1
    preDivCode = 2'b01;
    checkFrame(1'b0, 0, 1, "R3 code 01 period");
    preDivCode = 2'b11;
    checkFrame(1'b0, 0, 1, "R3 code 11 period");
    preDivCode = 2'b00;
    // R1: PLL source (pulse every 3 cycles) while master ticks keep running
    srcSel = 1'b1;
    checkFrame(1'b0, 0, 3, "R1 pll period");
    srcSel = 1'b0;
    checkFrame(1'b0, 0, 1, "R1 mclk period");

    // R9: code change mid-frame
    n = 0;
    do begin @(negedge clk); n++; end while (!adcFrameStart && n < 5000);
    repeat (50) @(negedge clk);
    adcRateCode = 3'd6;
    n = 0;
    do begin @(negedge clk); n++; end while (!adcFrameStart && n < 5000);
    check(50 + n == 256, "R9 old frame kept", 50 + n, 256);
    per = 0;
    do begin @(negedge clk); per++; end while (!adcFrameStart && per < 5000);
    check(per == 1536, "R9 new frame", per, 1536);

    // R8: reserved rate code on the DAC divider
    dacRateCode = 3'd7;
    repeat (600) @(negedge clk);
    check(dacRateErr == 1'b1, "R8 error flag set", dacRateErr, 1);
    seen = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (dacFrameStart || dacFrameClk) seen++;
    end
    check(seen == 0, "R8 stopped clock", seen, 0);
    check(adcRateErr == 1'b0, "R5 adc unaffected", adcRateErr, 0);
    dacRateCode = 3'd2;
    n = 0;
    do begin @(negedge clk); n++; end while (!dacFrameStart && n < 5000);
    check(n <= 2, "R8 restart delay", n, 1);
    check(dacRateErr == 1'b0, "R8 error flag cleared", dacRateErr, 0);
    per = 0;
    hi = 0;
    do begin @(negedge clk); per++; if (dacFrameClk) hi++; end while (!dacFrameStart && per < 5000);
    check(per == 512, "R8 restart period", per, 512);
    check(hi == 256, "R6 restart duty", hi, 256);

    // R7: strobe aligned with frame clock rise
    n = 0;
    do begin @(negedge clk); n++; end while (!adcFrameStart && n < 5000);
    check(adcFrameClk == 1'b1, "R7 strobe with clock high", adcFrameClk, 1);
    @(negedge clk);
    check(adcFrameStart == 1'b0, "R7 strobe one cycle", adcFrameStart, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule